// File: doc/BRIEF.md
# Multi-format signed integer codec

This block translates 4-bit code words between six number formats and a common 6-bit two's complement value. The decode path takes a code word and a format select and returns the value the code stands for. It also raises a flag when the code is one of the two negative-zero patterns. The encode path takes a 6-bit signed value and the same format select. It returns the code word for that value, or it raises a not-representable flag when the value lies outside the chosen format's range.

Both paths share one format select. They work independently, so one code word can be decoded while another value is encoded in the same cycle. A parameter decides whether the outputs are registered, which gives one cycle of latency, or taken straight from the combinational logic. Typical uses are glue logic between units that keep numbers in different formats, and display or debug paths that need the true value of a stored word.

Top module: `sgnfmt_codec`

## Requirements
- R1: The format select takes these values: 0 unsigned, 1 sign-magnitude, 2 ones' complement, 3 two's complement, 4 excess-8, 5 base -2. The values 6 and 7 are reserved. For a reserved value, `fmt_err` is 1, `dec_value` is 0, `dec_negzero` is 0, `enc_code` is 0000 and `enc_unrep` is 1. For any legal value, `fmt_err` is 0.
- R2: Unsigned decodes code c as c, giving 0 to 15. It encodes the values 0 to 15 as their 4-bit binary pattern.
- R3: Sign-magnitude uses bit 3 as the sign and bits 2..0 as the magnitude, covering -7 to +7. Code 1000 decodes to 0 with `dec_negzero` = 1, and code 1111 decodes to -7.
- R4: In ones' complement, a negative code is the bitwise inverse of the code for its magnitude, covering -7 to +7. Code 1111 decodes to 0 with `dec_negzero` = 1.
- R5: Two's complement sign-extends the code, covering -8 to +7. Code 1000 decodes to -8.
- R6: In excess-8, the code read as unsigned equals the value plus 8. Code 0000 decodes to -8 and code 1000 decodes to 0.
- R7: In base -2, bits 0 to 3 carry the weights +1, -2, +4 and -8, giving the range -10 to +5. Encoding produces the one code whose weighted sum equals the value.
- R8: For a legal format, an encode value outside that format's range drives `enc_code` to 0000 and `enc_unrep` to 1. For a value inside the range, `enc_unrep` is 0.
- R9: Encoding the value 0 in sign-magnitude or in ones' complement always gives 0000, never the negative-zero code.
- R10: With `OUT_REG` = 1, every output changes one clock edge after its inputs change. While `rst_n` is low, all outputs are held at 0.
- R11: `dec_negzero` is 0 for every code in formats 0, 3, 4 and 5, and for every code in formats 1 and 2 other than their negative-zero pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| fmt_sel | input | 3 | Format select shared by both paths |
| dec_code | input | 4 | Code word to decode |
| enc_value | input | 6 | Signed value to encode, two's complement |
| dec_value | output | 6 | Decoded value, two's complement |
| dec_negzero | output | 1 | Decoded code is a negative-zero pattern |
| enc_code | output | 4 | Encoded code word |
| enc_unrep | output | 1 | Value cannot be represented in the selected format |
| fmt_err | output | 1 | Format select is reserved |

## Verification
The bench sweeps all 16 codes through every format, and all 64 input values through every encoder. This exposes a flipped weight sign in base -2: that error would move the range to the wrong side of zero and break every odd-position bit. It also exposes a bias of 7 instead of 8 in excess-8, or a sign-magnitude decoder that inverts the magnitude. The range edges, such as -10 and -11 in base -2, -7 and -8 in sign-magnitude, and 15 and 16 in unsigned, show an off-by-one in a bound: the encoder would either reject a legal value or emit a wrapped code without flagging it. Encoding zero in the two formats that have a negative zero shows a design that picks the wrong zero. The reserved selects and the one-edge latency are checked against stale or leftover outputs.

// File: rtl/sgnfmt_pkg.sv
package sgnfmt_pkg;

  localparam int CW = 4;
  localparam int VW = 6;
  localparam int FW = 3;

  typedef enum logic [FW-1:0] {
    FMT_UNS  = 3'd0,
    FMT_SGM  = 3'd1,
    FMT_ONC  = 3'd2,
    FMT_TWC  = 3'd3,
    FMT_EX8  = 3'd4,
    FMT_NEG2 = 3'd5
  } fmt_e;

  localparam logic signed [VW-1:0] EX_BIAS  = VW'(1 << (CW - 1));
  localparam logic        [VW-1:0] NEG2_MSK = VW'(10);

  function automatic logic fmt_legal(logic [FW-1:0] f);
    return f <= FMT_NEG2;
  endfunction

  function automatic logic signed [VW-1:0] zext(logic [CW-1:0] c);
    return $signed({{(VW-CW){1'b0}}, c});
  endfunction

  function automatic logic signed [VW-1:0] sext(logic [CW-1:0] c);
    return $signed({{(VW-CW){c[CW-1]}}, c});
  endfunction

  // Weighted sum with alternating signs of the bit weights.
  function automatic logic signed [VW-1:0] neg2_sum(logic [CW-1:0] c);
    logic signed [VW-1:0] acc;
    acc = '0;
    for (int i = 0; i < CW; i++) begin
      if (c[i]) begin
        if (i % 2 == 1) acc = acc - VW'(1 << i);
        else            acc = acc + VW'(1 << i);
      end
    end
    return acc;
  endfunction

  function automatic logic signed [VW-1:0] range_lo(logic [FW-1:0] f);
    case (f)
      FMT_UNS:          return '0;
      FMT_SGM, FMT_ONC: return -VW'((1 << (CW - 1)) - 1);
      FMT_TWC, FMT_EX8: return -EX_BIAS;
      FMT_NEG2:         return neg2_sum(4'b1010);
      default:          return '0;
    endcase
  endfunction

  function automatic logic signed [VW-1:0] range_hi(logic [FW-1:0] f);
    case (f)
      FMT_UNS:                   return VW'((1 << CW) - 1);
      FMT_SGM, FMT_ONC, FMT_TWC,
      FMT_EX8:                   return VW'((1 << (CW - 1)) - 1);
      FMT_NEG2:                  return neg2_sum(4'b0101);
      default:                   return '0;
    endcase
  endfunction

  function automatic logic signed [VW-1:0] decode_val(logic [FW-1:0] f, logic [CW-1:0] c);
    logic [CW-1:0] mag;
    mag = {1'b0, c[CW-2:0]};
    case (f)
      FMT_UNS:  return zext(c);
      FMT_SGM:  return c[CW-1] ? -zext(mag) : zext(mag);
      FMT_ONC:  return c[CW-1] ? -zext({1'b0, ~c[CW-2:0]}) : zext(mag);
      FMT_TWC:  return sext(c);
      FMT_EX8:  return zext(c) - EX_BIAS;
      FMT_NEG2: return neg2_sum(c);
      default:  return '0;
    endcase
  endfunction

  function automatic logic decode_negz(logic [FW-1:0] f, logic [CW-1:0] c);
    return ((f == FMT_SGM) && (c == {1'b1, {(CW-1){1'b0}}})) ||
           ((f == FMT_ONC) && (&c));
  endfunction

  function automatic logic [CW-1:0] encode_raw(logic [FW-1:0] f, logic signed [VW-1:0] v);
    logic signed [VW-1:0] mag;
    logic        [VW-1:0] tmp;
    mag = -v;
    tmp = '0;
    case (f)
      FMT_SGM:  tmp = v[VW-1] ? VW'({1'b1, mag[CW-2:0]}) : v;
      FMT_ONC:  tmp = v[VW-1] ? VW'(~{1'b0, mag[CW-2:0]}) : v;
      FMT_EX8:  tmp = v + EX_BIAS;
      FMT_NEG2: tmp = (v + NEG2_MSK) ^ NEG2_MSK;
      default:  tmp = v;
    endcase
    return tmp[CW-1:0];
  endfunction

endpackage

// File: rtl/sgnfmt_decoder.sv
module sgnfmt_decoder
  import sgnfmt_pkg::*;
(
  input  logic [FW-1:0]        fmt,
  input  logic [CW-1:0]        code,
  output logic signed [VW-1:0] value,
  output logic                 negz
);
  always_comb begin
    value = decode_val(fmt, code);
    negz  = decode_negz(fmt, code);
  end
endmodule

// File: rtl/sgnfmt_encoder.sv
module sgnfmt_encoder
  import sgnfmt_pkg::*;
(
  input  logic [FW-1:0]        fmt,
  input  logic signed [VW-1:0] value,
  output logic [CW-1:0]        code,
  output logic                 unrep
);
  logic in_range;

  always_comb begin
    in_range = fmt_legal(fmt) && (value >= range_lo(fmt)) && (value <= range_hi(fmt));
    unrep    = !in_range;
    code     = in_range ? encode_raw(fmt, value) : '0;
  end
endmodule

// File: rtl/sgnfmt_outstage.sv
module sgnfmt_outstage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/sgnfmt_codec.sv
module sgnfmt_codec
  import sgnfmt_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    fmt_sel,
  input  logic [3:0]    dec_code,
  input  logic [5:0]    enc_value,
  output logic [5:0]    dec_value,
  output logic          dec_negzero,
  output logic [3:0]    enc_code,
  output logic          enc_unrep,
  output logic          fmt_err
);
  localparam int BUS_W = VW + CW + 3;

  logic signed [VW-1:0] dec_val_raw;
  logic                 dec_negz_raw;
  logic [CW-1:0]        enc_code_raw;
  logic                 enc_unrep_raw;
  logic                 fmt_bad;
  logic [BUS_W-1:0]     bus_d;
  logic [BUS_W-1:0]     bus_q;

  assign fmt_bad = !fmt_legal(fmt_sel);

  sgnfmt_decoder u_dec (
    .fmt   (fmt_sel),
    .code  (dec_code),
    .value (dec_val_raw),
    .negz  (dec_negz_raw)
  );

  sgnfmt_encoder u_enc (
    .fmt   (fmt_sel),
    .value ($signed(enc_value)),
    .code  (enc_code_raw),
    .unrep (enc_unrep_raw)
  );

  assign bus_d = {fmt_bad, dec_negz_raw, dec_val_raw, enc_unrep_raw, enc_code_raw};

  sgnfmt_outstage #(.W(BUS_W), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_d),
    .q     (bus_q)
  );

  assign {fmt_err, dec_negzero, dec_value, enc_unrep, enc_code} = bus_q;
endmodule

// File: rtl/sgnfmt_chk.sv
module sgnfmt_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] fmt_sel,
  input logic [3:0] dec_code,
  input logic [5:0] dec_value,
  input logic       dec_negzero,
  input logic [3:0] enc_code,
  input logic       enc_unrep,
  input logic       fmt_err
);
  // R11
  negz_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_negzero |-> (dec_value == 6'd0 && !fmt_err));

  // R8
  unrep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_unrep |-> (enc_code == 4'd0));

  generate
    if (OUT_REG) begin : g_seq
      // R1
      reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel > 3'd5) |=> (fmt_err && enc_unrep && dec_value == 6'd0));

      // R1
      legal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel <= 3'd5) |=> !fmt_err);

      // R5
      twc_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 3'd3 && dec_code == 4'b1000) |=> (dec_value == 6'b111000));

      // R3
      sgm_negz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 3'd1 && dec_code == 4'b1000) |=> dec_negzero);
    end
  endgenerate
endmodule

bind sgnfmt_codec sgnfmt_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fmt_sel     (fmt_sel),
  .dec_code    (dec_code),
  .dec_value   (dec_value),
  .dec_negzero (dec_negzero),
  .enc_code    (enc_code),
  .enc_unrep   (enc_unrep),
  .fmt_err     (fmt_err)
);

// File: tb/sim_sgnfmt_codec.sv
module sim_sgnfmt_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] fmt_sel = 3'd0;
  logic [3:0] dec_code = 4'd0;
  logic [5:0] enc_value = 6'd0;
  logic [5:0] dec_value;
  logic       dec_negzero;
  logic [3:0] enc_code;
  logic       enc_unrep;
  logic       fmt_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sgnfmt_codec #(.OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .dec_code(dec_code),
    .enc_value(enc_value), .dec_value(dec_value), .dec_negzero(dec_negzero),
    .enc_code(enc_code), .enc_unrep(enc_unrep), .fmt_err(fmt_err)
  );

  // Reference value of code c under format f, from the bit weights.
  function automatic int ref_dec(int f, int c);
    int b3 = (c >> 3) & 1;
    int low = c & 7;
    case (f)
      0: return c;
      1: return b3 ? -low : low;
      2: return b3 ? -(7 - low) : low;
      3: return b3 ? c - 16 : c;
      4: return c - 8;
      5: return (c & 1) - 2 * ((c >> 1) & 1) + 4 * ((c >> 2) & 1) - 8 * b3;
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_nz(int f, int c);
    return (f == 1 && c == 8) || (f == 2 && c == 15);
  endfunction

  // Search for the code of v; -1 when none exists.
  function automatic int ref_enc(int f, int v);
    if (f > 5) return -1;
    for (int c = 0; c < 16; c++)
      if (ref_dec(f, c) == v && !ref_nz(f, c)) return c;
    return -1;
  endfunction

  function automatic int sval();
    return int'($signed(dec_value));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge; outputs settle after the next rising edge.
  task automatic apply(int f, int c, int v);
    fmt_sel   = 3'(f);
    dec_code  = 4'(c);
    enc_value = 6'(v);
    @(negedge clk);
  endtask

  task automatic t_reset();
    fmt_sel = 3'd7; dec_code = 4'hF; enc_value = 6'd40;
    repeat (3) @(negedge clk);
    chk("R10 reset dec_value", int'(dec_value), 0);
    chk("R10 reset negzero", int'(dec_negzero), 0);
    chk("R10 reset enc_code", int'(enc_code), 0);
    chk("R10 reset unrep", int'(enc_unrep), 0);
    chk("R10 reset fmt_err", int'(fmt_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_decode(int f, string req);
    for (int c = 0; c < 16; c++) begin
      apply(f, c, 0);
      chk({req, " decode value"}, sval(), ref_dec(f, c));
      chk({"R11 ", req, " negzero"}, int'(dec_negzero), int'(ref_nz(f, c)));
      chk("R1 fmt_err legal", int'(fmt_err), 0);
    end
  endtask

  task automatic t_encode(int f, string req);
    for (int v = -32; v < 32; v++) begin
      int e = ref_enc(f, v);
      apply(f, 0, v);
      chk({"R8 ", req, " unrep"}, int'(enc_unrep), int'(e < 0));
      chk({req, " encode code"}, int'(enc_code), (e < 0) ? 0 : e);
    end
  endtask

  task automatic t_zero();
    apply(1, 0, 0);
    chk("R9 sign-magnitude zero code", int'(enc_code), 0);
    chk("R9 sign-magnitude zero unrep", int'(enc_unrep), 0);
    apply(2, 0, 0);
    chk("R9 ones complement zero code", int'(enc_code), 0);
    chk("R9 ones complement zero unrep", int'(enc_unrep), 0);
  endtask

  task automatic t_reserved();
    for (int f = 6; f < 8; f++) begin
      apply(f, 9, 3);
      chk("R1 reserved fmt_err", int'(fmt_err), 1);
      chk("R1 reserved dec_value", int'(dec_value), 0);
      chk("R1 reserved negzero", int'(dec_negzero), 0);
      chk("R1 reserved enc_code", int'(enc_code), 0);
      chk("R1 reserved unrep", int'(enc_unrep), 1);
    end
  endtask

  task automatic t_latency();
    apply(3, 4'b0111, 7);
    fmt_sel = 3'd3; dec_code = 4'b1000; enc_value = 6'(-8);
    #1;
    chk("R10 no change before edge value", sval(), 7);
    chk("R10 no change before edge code", int'(enc_code), 7);
    @(negedge clk);
    chk("R10 update after edge value", sval(), -8);
    chk("R10 update after edge code", int'(enc_code), 8);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_decode(0, "R2");
    t_decode(1, "R3");
    t_decode(2, "R4");
    t_decode(3, "R5");
    t_decode(4, "R6");
    t_decode(5, "R7");
    t_encode(0, "R2");
    t_encode(1, "R3");
    t_encode(2, "R4");
    t_encode(3, "R5");
    t_encode(4, "R6");
    t_encode(5, "R7");
    t_zero();
    t_reserved();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule